// File: doc/BRIEF.md
# Raster-Op Pixel Mixer with Color-Compare Skip

This block is the final write stage of a 2D drawing engine's pixel path. Each pixel arrives as a pair: the source value chosen upstream and the destination value already read from the frame buffer. The block decides whether the pixel must be left alone (a color-compare test), combines source and destination through a selectable mix function, and merges the mixed value into the old destination under a plane write mask. What it hands back is the word to write to memory and a flag telling the writer that the pixel was skipped.

Drawing settings (mix code, compare function, compare source select, compare color, compare mask and write mask) are captured into internal registers by a one-cycle load strobe and then stay fixed for the pixels that follow. Pixels flow through a single register stage with a valid/ready handshake on both sides, so a stalled memory writer holds the result and back-pressures the pixel source without losing data.

Top module: `rop_pixel_mixer`

## Requirements
- R1: After reset out_valid is 0 and in_ready is 1; the settings default to mix code 0x07 (source copy), compare function 0, compare color 0, compare mask all ones and write mask all ones.
- R2: Mix codes 0x00 to 0x0F give, in order: NOT dst, all zeros, all ones, dst, NOT src, src XOR dst, NOT (src XOR dst), src, NOT (src AND dst), NOT src OR dst, src OR NOT dst, src OR dst, src AND dst, src AND NOT dst, NOT src AND dst, NOT (src OR dst).
- R3: Mix code 0x17 gives the average (src + dst) >> 1, with the sum formed one bit wider than a pixel so the carry is kept as the top result bit.
- R4: Any mix code outside 0x00 to 0x0F and 0x17 passes the source through unchanged.
- R5: Compare function 1 always hits; on a hit the output pixel equals the input destination and out_skip is 1, whatever the mix code and write mask.
- R6: Compare function 4 hits when (tested color AND compare mask) differs from the stored compare color; function 5 hits when they are equal. The tested color is the source when cfg_cmp_use_src is 1 and the destination when it is 0.
- R7: The compare color is stored already ANDed with the compare mask when the settings are loaded.
- R8: Compare function codes other than 1, 4 and 5 never hit.
- R9: Without a hit the output is (mixed AND write mask) OR (destination AND NOT write mask), and out_skip is 0.
- R10: Settings change only in the cycle after cfg_load is 1; setting inputs are ignored at other times, and a pixel accepted in the same cycle as a load uses the previous settings.
- R11: A pixel accepted at a clock edge appears on the output after that edge; in_ready is 1 whenever the output register is empty or out_ready is 1, and a stalled output keeps its value and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_load | input | 1 | Strobe that captures all setting inputs |
| cfg_mix | input | 5 | Mix code |
| cfg_cmp_fn | input | 3 | Compare function code |
| cfg_cmp_use_src | input | 1 | 1: test the source color, 0: test the destination |
| cfg_cmp_color | input | PIX_W | Compare color |
| cfg_cmp_mask | input | PIX_W | Compare mask |
| cfg_write_mask | input | PIX_W | Plane write mask, 1 = bit takes the mixed value |
| in_valid | input | 1 | Pixel pair offered |
| in_ready | output | 1 | Pixel pair accepted when high with in_valid |
| in_src | input | PIX_W | Source pixel |
| in_dst | input | PIX_W | Destination pixel read from memory |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Writer takes the result |
| out_pix | output | PIX_W | Pixel to write back |
| out_skip | output | 1 | Pixel was left unchanged by the compare test |

## Verification
The bench goes after the three compare functions with both tested-color choices, where a design that swapped the equal and not-equal senses, or tested the wrong operand, would write mixed data over pixels meant to be kept. A compare color carrying bits outside the mask exposes a design that forgets to pre-mask it, which would then never find a match. The averaging mode is driven with operands whose sum overflows a pixel, catching a design that drops the carry and returns a small value instead of one with the top bit set. Partial write masks, a load strobe coinciding with a pixel, setting inputs changed without a strobe, and a held output under back-pressure catch designs that leak mixed bits into protected planes, apply settings a cycle early, or overwrite a stalled result.

// File: rtl/rop_mix_pkg.sv
package rop_mix_pkg;

    localparam int MIX_CODE_W = 5;
    localparam int CMP_FN_W   = 3;

    // Boolean mix codes
    localparam logic [MIX_CODE_W-1:0] MIX_NOT_D    = 5'h00;
    localparam logic [MIX_CODE_W-1:0] MIX_ZERO     = 5'h01;
    localparam logic [MIX_CODE_W-1:0] MIX_ONES     = 5'h02;
    localparam logic [MIX_CODE_W-1:0] MIX_D        = 5'h03;
    localparam logic [MIX_CODE_W-1:0] MIX_NOT_S    = 5'h04;
    localparam logic [MIX_CODE_W-1:0] MIX_XOR      = 5'h05;
    localparam logic [MIX_CODE_W-1:0] MIX_XNOR     = 5'h06;
    localparam logic [MIX_CODE_W-1:0] MIX_S        = 5'h07;
    localparam logic [MIX_CODE_W-1:0] MIX_NAND     = 5'h08;
    localparam logic [MIX_CODE_W-1:0] MIX_NS_OR_D  = 5'h09;
    localparam logic [MIX_CODE_W-1:0] MIX_S_OR_ND  = 5'h0A;
    localparam logic [MIX_CODE_W-1:0] MIX_OR       = 5'h0B;
    localparam logic [MIX_CODE_W-1:0] MIX_AND      = 5'h0C;
    localparam logic [MIX_CODE_W-1:0] MIX_S_AND_ND = 5'h0D;
    localparam logic [MIX_CODE_W-1:0] MIX_NS_AND_D = 5'h0E;
    localparam logic [MIX_CODE_W-1:0] MIX_NOR      = 5'h0F;
    // Arithmetic mix code
    localparam logic [MIX_CODE_W-1:0] MIX_AVG      = 5'h17;

    // Compare function codes
    localparam logic [CMP_FN_W-1:0] CMP_ALWAYS = 3'd1;
    localparam logic [CMP_FN_W-1:0] CMP_NEQ    = 3'd4;
    localparam logic [CMP_FN_W-1:0] CMP_EQ     = 3'd5;

    // Settings after reset
    localparam logic [MIX_CODE_W-1:0] MIX_RESET    = MIX_S;
    localparam logic [CMP_FN_W-1:0]   CMP_FN_RESET = 3'd0;

endpackage

// File: rtl/rop_cmp_unit.sv
module rop_cmp_unit
    import rop_mix_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic [CMP_FN_W-1:0] fn,
    input  logic                use_src,
    input  logic [PIX_W-1:0]    cmp_mask,
    input  logic [PIX_W-1:0]    cmp_color,
    input  logic [PIX_W-1:0]    src,
    input  logic [PIX_W-1:0]    dst,
    output logic                hit
);

    logic [PIX_W-1:0] tested;
    logic             match;

    always_comb begin
        tested = (use_src ? src : dst) & cmp_mask;
        match  = (tested == cmp_color);
        case (fn)
            CMP_ALWAYS: hit = 1'b1;
            CMP_NEQ:    hit = !match;
            CMP_EQ:     hit = match;
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/rop_mix_unit.sv
module rop_mix_unit
    import rop_mix_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic [MIX_CODE_W-1:0] code,
    input  logic [PIX_W-1:0]      src,
    input  logic [PIX_W-1:0]      dst,
    output logic [PIX_W-1:0]      mixed
);

    localparam int SUM_W = PIX_W + 1;

    logic [SUM_W-1:0] sum_wide;
    logic [PIX_W-1:0] avg;

    always_comb begin
        sum_wide = {1'b0, src} + {1'b0, dst};
        avg      = PIX_W'(sum_wide >> 1);
    end

    always_comb begin
        case (code)
            MIX_NOT_D:    mixed = ~dst;
            MIX_ZERO:     mixed = '0;
            MIX_ONES:     mixed = '1;
            MIX_D:        mixed = dst;
            MIX_NOT_S:    mixed = ~src;
            MIX_XOR:      mixed = src ^ dst;
            MIX_XNOR:     mixed = ~(src ^ dst);
            MIX_S:        mixed = src;
            MIX_NAND:     mixed = ~(src & dst);
            MIX_NS_OR_D:  mixed = ~src | dst;
            MIX_S_OR_ND:  mixed = src | ~dst;
            MIX_OR:       mixed = src | dst;
            MIX_AND:      mixed = src & dst;
            MIX_S_AND_ND: mixed = src & ~dst;
            MIX_NS_AND_D: mixed = ~src & dst;
            MIX_NOR:      mixed = ~(src | dst);
            MIX_AVG:      mixed = avg;
            default:      mixed = src;
        endcase
    end

endmodule

// File: rtl/rop_mask_merge.sv
module rop_mask_merge #(
    parameter int PIX_W = 32
) (
    input  logic             hold,
    input  logic [PIX_W-1:0] write_mask,
    input  logic [PIX_W-1:0] mixed,
    input  logic [PIX_W-1:0] old_dst,
    output logic [PIX_W-1:0] result
);

    for (genvar b = 0; b < PIX_W; b++) begin : g_plane
        assign result[b] = (hold || !write_mask[b]) ? old_dst[b] : mixed[b];
    end

endmodule

// File: rtl/rop_pixel_mixer.sv
module rop_pixel_mixer
    import rop_mix_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_load,
    input  logic [MIX_CODE_W-1:0] cfg_mix,
    input  logic [CMP_FN_W-1:0]   cfg_cmp_fn,
    input  logic                  cfg_cmp_use_src,
    input  logic [PIX_W-1:0]      cfg_cmp_color,
    input  logic [PIX_W-1:0]      cfg_cmp_mask,
    input  logic [PIX_W-1:0]      cfg_write_mask,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [PIX_W-1:0]      in_src,
    input  logic [PIX_W-1:0]      in_dst,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [PIX_W-1:0]      out_pix,
    output logic                  out_skip
);

    typedef struct packed {
        logic [MIX_CODE_W-1:0] mix;
        logic [CMP_FN_W-1:0]   cmp_fn;
        logic                  cmp_use_src;
        logic [PIX_W-1:0]      cmp_color;
        logic [PIX_W-1:0]      cmp_mask;
        logic [PIX_W-1:0]      wr_mask;
        logic                  o_valid;
        logic [PIX_W-1:0]      o_pix;
        logic                  o_skip;
    } state_t;

    state_t st_d, st_q;

    logic             hit;
    logic [PIX_W-1:0] mixed;
    logic [PIX_W-1:0] merged;
    logic             take_pix;

    rop_cmp_unit #(.PIX_W(PIX_W)) u_cmp (
        .fn        (st_q.cmp_fn),
        .use_src   (st_q.cmp_use_src),
        .cmp_mask  (st_q.cmp_mask),
        .cmp_color (st_q.cmp_color),
        .src       (in_src),
        .dst       (in_dst),
        .hit       (hit)
    );

    rop_mix_unit #(.PIX_W(PIX_W)) u_mix (
        .code  (st_q.mix),
        .src   (in_src),
        .dst   (in_dst),
        .mixed (mixed)
    );

    rop_mask_merge #(.PIX_W(PIX_W)) u_merge (
        .hold       (hit),
        .write_mask (st_q.wr_mask),
        .mixed      (mixed),
        .old_dst    (in_dst),
        .result     (merged)
    );

    assign in_ready  = !st_q.o_valid || out_ready;
    assign take_pix  = in_valid && in_ready;
    assign out_valid = st_q.o_valid;
    assign out_pix   = st_q.o_pix;
    assign out_skip  = st_q.o_skip;

    always_comb begin
        st_d = st_q;
        if (cfg_load) begin
            st_d.mix         = cfg_mix;
            st_d.cmp_fn      = cfg_cmp_fn;
            st_d.cmp_use_src = cfg_cmp_use_src;
            st_d.cmp_mask    = cfg_cmp_mask;
            st_d.cmp_color   = cfg_cmp_color & cfg_cmp_mask;
            st_d.wr_mask     = cfg_write_mask;
        end
        if (take_pix) begin
            st_d.o_valid = 1'b1;
            st_d.o_pix   = merged;
            st_d.o_skip  = hit;
        end else if (out_ready) begin
            st_d.o_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mix         <= MIX_RESET;
            st_q.cmp_fn      <= CMP_FN_RESET;
            st_q.cmp_use_src <= 1'b0;
            st_q.cmp_color   <= '0;
            st_q.cmp_mask    <= '1;
            st_q.wr_mask     <= '1;
            st_q.o_valid     <= 1'b0;
            st_q.o_pix       <= '0;
            st_q.o_skip      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rop_pixel_mixer_chk.sv
module rop_pixel_mixer_chk
    import rop_mix_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_load,
    input logic [CMP_FN_W-1:0] cfg_cmp_fn,
    input logic                in_valid,
    input logic                in_ready,
    input logic [PIX_W-1:0]    in_dst,
    input logic                out_valid,
    input logic                out_ready,
    input logic [PIX_W-1:0]    out_pix,
    input logic                out_skip
);

    logic [CMP_FN_W-1:0] fn_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fn_seen_q <= CMP_FN_RESET;
        else if (cfg_load) fn_seen_q <= cfg_cmp_fn;
    end

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_skip)));

    // R11
    accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R11
    ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R5
    skip_keeps_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!out_skip || out_pix == $past(in_dst)));

    // R5
    always_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !cfg_load && fn_seen_q == CMP_ALWAYS) |=> out_skip);

    // R8
    no_hit_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && fn_seen_q != CMP_ALWAYS && fn_seen_q != CMP_NEQ
         && fn_seen_q != CMP_EQ) |=> !out_skip);

endmodule

bind rop_pixel_mixer rop_pixel_mixer_chk #(.PIX_W(PIX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load   (cfg_load),
    .cfg_cmp_fn (cfg_cmp_fn),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_dst     (in_dst),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_pix    (out_pix),
    .out_skip   (out_skip)
);

// File: tb/tb_rop_pixel_mixer.sv
`timescale 1ns/1ps
module tb_rop_pixel_mixer;

    localparam int W = 32;
    localparam logic [W-1:0] S  = 32'hF0F0_00FF;
    localparam logic [W-1:0] D  = 32'hCCCC_0F0F;
    localparam logic [W-1:0] AL = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [4:0]   mix;
        logic [2:0]   fn;
        logic         usrc;
        logic [W-1:0] ccol;
        logic [W-1:0] cmask;
        logic [W-1:0] wm;
        logic [W-1:0] src;
        logic [W-1:0] dst;
        logic [W-1:0] exp_pix;
        logic         exp_skip;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{5'h07, 3'd0, 1'b0, 32'h0, AL, AL, S, D, 32'hF0F000FF, 1'b0, 4'd2},  // R2 copy
        '{5'h0D, 3'd0, 1'b0, 32'h0, AL, AL, S, D, 32'h303000F0, 1'b0, 4'd2},  // R2
        '{5'h0E, 3'd0, 1'b0, 32'h0, AL, AL, S, D, 32'h0C0C0F00, 1'b0, 4'd2},  // R2
        '{5'h0F, 3'd0, 1'b0, 32'h0, AL, AL, S, D, 32'h0303F000, 1'b0, 4'd2},  // R2
        '{5'h05, 3'd0, 1'b0, 32'h0, AL, AL, S, D, 32'h3C3C0FF0, 1'b0, 4'd2},  // R2
        '{5'h0C, 3'd0, 1'b0, 32'h0, AL, AL, S, D, 32'hC0C0000F, 1'b0, 4'd2},  // R2
        '{5'h0B, 3'd0, 1'b0, 32'h0, AL, AL, S, D, 32'hFCFC0FFF, 1'b0, 4'd2},  // R2
        '{5'h06, 3'd0, 1'b0, 32'h0, AL, AL, S, D, 32'hC3C3F00F, 1'b0, 4'd2},  // R2
        '{5'h17, 3'd0, 1'b0, 32'h0, AL, AL, 32'h10, 32'h20, 32'h18, 1'b0, 4'd3},  // R3
        '{5'h17, 3'd0, 1'b0, 32'h0, AL, AL, AL, 32'h3, 32'h80000001, 1'b0, 4'd3}, // R3 carry
        '{5'h10, 3'd0, 1'b0, 32'h0, AL, AL, 32'h12345678, D, 32'h12345678, 1'b0, 4'd4}, // R4
        '{5'h1F, 3'd0, 1'b0, 32'h0, AL, AL, S, D, S, 1'b0, 4'd4},             // R4
        '{5'h01, 3'd0, 1'b0, 32'h0, AL, 32'h0000FFFF, S, D, 32'hCCCC0000, 1'b0, 4'd9}, // R9
        '{5'h02, 3'd0, 1'b0, 32'h0, AL, 32'hFF00FF00, S, D, 32'hFFCCFF0F, 1'b0, 4'd9}, // R9
        '{5'h02, 3'd1, 1'b0, 32'h0, AL, AL, S, D, D, 1'b1, 4'd5},             // R5
        '{5'h02, 3'd5, 1'b0, 32'h1234560F, 32'hFF, AL, S, D, D, 1'b1, 4'd7},  // R7
        '{5'h01, 3'd5, 1'b1, 32'h1234560F, 32'hFF, AL, S, D, 32'h0, 1'b0, 4'd6}, // R6
        '{5'h02, 3'd4, 1'b1, 32'h0F, 32'hFF, AL, S, D, D, 1'b1, 4'd6},        // R6
        '{5'h00, 3'd4, 1'b0, 32'h0F, 32'hFF, AL, S, D, 32'h3333F0F0, 1'b0, 4'd6}, // R6
        '{5'h07, 3'd3, 1'b0, 32'h0F, 32'hFF, AL, S, D, S, 1'b0, 4'd8},        // R8
        '{5'h07, 3'd6, 1'b0, 32'h0F, 32'hFF, AL, S, D, S, 1'b0, 4'd8}         // R8
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_load = 1'b0;
    logic [4:0]   cfg_mix = '0;
    logic [2:0]   cfg_cmp_fn = '0;
    logic         cfg_cmp_use_src = 1'b0;
    logic [W-1:0] cfg_cmp_color = '0;
    logic [W-1:0] cfg_cmp_mask = '0;
    logic [W-1:0] cfg_write_mask = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_src = '0;
    logic [W-1:0] in_dst = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [W-1:0] out_pix;
    logic         out_skip;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rop_pixel_mixer #(.PIX_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mix(cfg_mix),
        .cfg_cmp_fn(cfg_cmp_fn), .cfg_cmp_use_src(cfg_cmp_use_src),
        .cfg_cmp_color(cfg_cmp_color), .cfg_cmp_mask(cfg_cmp_mask),
        .cfg_write_mask(cfg_write_mask), .in_valid(in_valid), .in_ready(in_ready),
        .in_src(in_src), .in_dst(in_dst), .out_valid(out_valid), .out_ready(out_ready),
        .out_pix(out_pix), .out_skip(out_skip)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic load_cfg(input vec_t v);
        @(negedge clk);
        cfg_load = 1'b1; cfg_mix = v.mix; cfg_cmp_fn = v.fn; cfg_cmp_use_src = v.usrc;
        cfg_cmp_color = v.ccol; cfg_cmp_mask = v.cmask; cfg_write_mask = v.wm;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Offers one pixel at the current negedge, checks result one edge later
    task automatic one_pixel(input string req, input logic [W-1:0] s, input logic [W-1:0] d,
                             input logic [W-1:0] ep, input logic es);
        in_valid = 1'b1; in_src = s; in_dst = d;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {31'b0, out_valid}, 32'd1);
        check(req, out_pix, ep);
        check(req, {31'b0, out_skip}, {31'b0, es});
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 out_valid", {31'b0, out_valid}, 32'd0);
        check("R1 in_ready", {31'b0, in_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 default settings: source copy, no compare, full write mask
        one_pixel("R1 default", S, D, S, 1'b0);

        for (int i = 0; i < NV; i++) begin
            load_cfg(VECS[i]);
            one_pixel($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].src, VECS[i].dst,
                      VECS[i].exp_pix, VECS[i].exp_skip);
        end

        // R10: inputs changed without strobe are ignored (last load: mix 0x07, fn 6)
        cfg_mix = 5'h01; cfg_write_mask = '0; cfg_cmp_fn = 3'd1;
        @(negedge clk);
        one_pixel("R10 no strobe", 32'hA5A5A5A5, D, 32'hA5A5A5A5, 1'b0);

        // R10: pixel in the load cycle uses old settings, next one the new (zero)
        cfg_load = 1'b1; cfg_mix = 5'h01; cfg_cmp_fn = 3'd0; cfg_write_mask = AL;
        in_valid = 1'b1; in_src = 32'h11111111; in_dst = D;
        @(negedge clk);
        cfg_load = 1'b0; in_src = 32'h22222222;
        check("R10 same-cycle old", out_pix, 32'h11111111);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 next new", out_pix, 32'h0);
        @(negedge clk);

        // R11 back-pressure (settings back to source copy)
        load_cfg('{5'h07, 3'd0, 1'b0, 32'h0, AL, AL, 32'h0, 32'h0, 32'h0, 1'b0, 4'd11});
        out_ready = 1'b0;
        in_valid = 1'b1; in_src = 32'hAAAA0001; in_dst = D;
        @(negedge clk);
        check("R11 first out", out_pix, 32'hAAAA0001);
        check("R11 ready low", {31'b0, in_ready}, 32'd0);
        in_src = 32'hBBBB0002;
        @(negedge clk);
        check("R11 held", out_pix, 32'hAAAA0001);
        check("R11 held valid", {31'b0, out_valid}, 32'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 second out", out_pix, 32'hBBBB0002);
        check("R11 second valid", {31'b0, out_valid}, 32'd1);
        @(negedge clk);
        check("R11 drained", {31'b0, out_valid}, 32'd0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule